// File: doc/BRIEF.md
# External Data Space Address Router

This block sits between the core's data-memory move logic and the external memory interface. For every data-memory access it decides whether the move is served by on-chip RAM or by the off-chip bus. For an off-chip access it also forms the external address and reports which half of that address the interface must drive onto pins. It is purely combinational. The results are valid in the same cycle as the access request.

Two mapping schemes are supported.

- **Split-with-page:** the data space is divided at a fixed on-chip boundary. Short (8-bit pointer) accesses take their page from a 4-bit page register.
- **All-external:** every access goes to the bus. Short accesses leave the upper address lines undriven, so that port logic keeps ownership of them.

Internally each request is classified into one of four routes. The route then decides the outputs in one place.

| Route | Meaning |
|---|---|
| `ROUTE_IDLE` | No request is present. |
| `ROUTE_ONCHIP` | The access is served by on-chip RAM. |
| `ROUTE_OFF_FULL` | The access goes off-chip and drives all 12 address lines. |
| `ROUTE_OFF_LOW` | The access goes off-chip and drives only the low 8 address lines. |

The classification moves between routes as follows:

- A low request always gives `ROUTE_IDLE`.
- In split mode, an address below the boundary gives `ROUTE_ONCHIP`, and any other address gives `ROUTE_OFF_FULL`.
- In all-external mode, a wide access gives `ROUTE_OFF_FULL` and a short access gives `ROUTE_OFF_LOW`.

Top module: `xds_addr_router`

## Requirements
- R1: Mode code 2'b10 selects split-with-page. Every other code (2'b11, and the unused 2'b00 and 2'b01) selects all-external.
- R2: In split mode, a short access (`wide_acc`=0) forms the effective address as {`page_reg`, `ind_ptr`}, with the page in bits 11:8. The access is on-chip when that address is below `BOUNDARY` (default 12'h400).
- R3: In split mode, an effective address equal to or above `BOUNDARY` goes off-chip. 12'h3FF is on-chip and 12'h400 is off-chip.
- R4: In split mode, an off-chip access raises both `drv_hi` and `drv_lo` and presents the full 12-bit effective address on `ext_addr`. An on-chip access raises `on_chip` and leaves `drv_hi`, `drv_lo` and `ext_addr` at zero.
- R5: A wide access (`wide_acc`=1) uses bits 11:0 of `data_ptr` as the effective address. Bits 15:12 of `data_ptr`, `page_reg` and `ind_ptr` have no effect on it.
- R6: In all-external mode, `on_chip` is never raised, even for addresses below `BOUNDARY`.
- R7: In all-external mode, a short access ignores `page_reg`. It raises `drv_lo` only, puts `ind_ptr` on `ext_addr[7:0]`, and holds `ext_addr[11:8]` at zero.
- R8: In all-external mode, a wide access raises both drive enables and puts `data_ptr[11:0]` on `ext_addr`.
- R9: Mode codes 2'b00 and 2'b01 give exactly the results of mode 2'b11 for the same inputs.
- R10: With `acc_req` low, `on_chip`, `drv_hi`, `drv_lo` and `ext_addr` are all zero.
- R11: The outputs follow the inputs in the same cycle, with no clock edge in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_req | input | 1 | Data-memory access request strobe |
| map_mode | input | 2 | Mapping mode code |
| wide_acc | input | 1 | 1 = 16-bit pointer access, 0 = 8-bit pointer access |
| ind_ptr | input | 8 | 8-bit indirect pointer value |
| data_ptr | input | 16 | 16-bit data pointer |
| page_reg | input | 4 | Page register supplying address bits 11:8 in split mode |
| on_chip | output | 1 | Access is served by on-chip RAM |
| ext_addr | output | 12 | External address |
| drv_hi | output | 1 | Drive enable for `ext_addr[11:8]` |
| drv_lo | output | 1 | Drive enable for `ext_addr[7:0]` |

## Verification
The checks assume that the inputs settle to known values before they are sampled. They also assume that `BOUNDARY` is a 12-bit value with the default 12'h400. The checks themselves are evaluated combinationally, whenever an input changes. The stimulus changes all inputs together on the falling clock edge and compares the outputs two nanoseconds later. This keeps every sample on a settled input set. The vectors sit on both sides of the boundary, carry upper data-pointer bits that must be dropped, and present page values that all-external mode must ignore.

// File: rtl/xds_pkg.sv
package xds_pkg;

    typedef enum logic [1:0] {
        MODE_RSVD_A     = 2'b00,
        MODE_RSVD_B     = 2'b01,
        MODE_SPLIT_PAGE = 2'b10,
        MODE_EXT_ONLY   = 2'b11
    } map_mode_e;

    typedef enum logic [1:0] {
        ROUTE_IDLE,
        ROUTE_ONCHIP,
        ROUTE_OFF_FULL,
        ROUTE_OFF_LOW
    } route_e;

endpackage

// File: rtl/xds_ea_former.sv
module xds_ea_former #(
    parameter int ADDR_W = 12,
    parameter int IND_W  = 8,
    parameter int PTR_W  = 16
) (
    input  logic                     split_sel,
    input  logic                     wide_acc,
    input  logic [IND_W-1:0]         ind_ptr,
    input  logic [PTR_W-1:0]         data_ptr,
    input  logic [ADDR_W-IND_W-1:0]  page_reg,
    output logic [ADDR_W-1:0]        eff_addr
);
    localparam int PAGE_W = ADDR_W - IND_W;

    // Bits of the pointer above the external address width never reach the bus (R5).
    logic unused_ptr_hi;
    assign unused_ptr_hi = ^data_ptr[PTR_W-1:ADDR_W];

    always_comb begin
        if (wide_acc) begin
            eff_addr = data_ptr[ADDR_W-1:0];
        end else if (split_sel) begin
            eff_addr = {page_reg, ind_ptr};
        end else begin
            eff_addr = {{PAGE_W{1'b0}}, ind_ptr};
        end
    end
endmodule

// File: rtl/xds_region_judge.sv
module xds_region_judge
    import xds_pkg::*;
#(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] BOUNDARY = 12'h400
) (
    input  logic              acc_req,
    input  logic              split_sel,
    input  logic              wide_acc,
    input  logic [ADDR_W-1:0] eff_addr,
    output route_e            route
);
    always_comb begin
        if (!acc_req) begin
            route = ROUTE_IDLE;
        end else if (split_sel) begin
            route = (eff_addr < BOUNDARY) ? ROUTE_ONCHIP : ROUTE_OFF_FULL;
        end else begin
            route = wide_acc ? ROUTE_OFF_FULL : ROUTE_OFF_LOW;
        end
    end
endmodule

// File: rtl/xds_pin_drive.sv
module xds_pin_drive
    import xds_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IND_W  = 8
) (
    input  route_e            route,
    input  logic [ADDR_W-1:0] eff_addr,
    output logic              on_chip,
    output logic [ADDR_W-1:0] ext_addr,
    output logic              drv_hi,
    output logic              drv_lo
);
    localparam int PAGE_W = ADDR_W - IND_W;

    always_comb begin
        on_chip  = 1'b0;
        drv_hi   = 1'b0;
        drv_lo   = 1'b0;
        ext_addr = '0;
        unique case (route)
            ROUTE_IDLE: begin
            end
            ROUTE_ONCHIP: begin
                on_chip = 1'b1;
            end
            ROUTE_OFF_FULL: begin
                drv_hi   = 1'b1;
                drv_lo   = 1'b1;
                ext_addr = eff_addr;
            end
            ROUTE_OFF_LOW: begin
                drv_lo   = 1'b1;
                ext_addr = {{PAGE_W{1'b0}}, eff_addr[IND_W-1:0]};
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/xds_addr_router.sv
module xds_addr_router
    import xds_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter int                IND_W    = 8,
    parameter int                PTR_W    = 16,
    parameter logic [ADDR_W-1:0] BOUNDARY = 12'h400
) (
    input  logic                    acc_req,
    input  logic [1:0]              map_mode,
    input  logic                    wide_acc,
    input  logic [IND_W-1:0]        ind_ptr,
    input  logic [PTR_W-1:0]        data_ptr,
    input  logic [ADDR_W-IND_W-1:0] page_reg,
    output logic                    on_chip,
    output logic [ADDR_W-1:0]       ext_addr,
    output logic                    drv_hi,
    output logic                    drv_lo
);
    logic              split_sel;
    logic [ADDR_W-1:0] eff_addr;
    route_e            route;

    // Only the split-with-page code maps on-chip; every other code is all-external (R1, R9).
    assign split_sel = (map_mode == MODE_SPLIT_PAGE);

    xds_ea_former #(
        .ADDR_W (ADDR_W),
        .IND_W  (IND_W),
        .PTR_W  (PTR_W)
    ) u_ea (
        .split_sel (split_sel),
        .wide_acc  (wide_acc),
        .ind_ptr   (ind_ptr),
        .data_ptr  (data_ptr),
        .page_reg  (page_reg),
        .eff_addr  (eff_addr)
    );

    xds_region_judge #(
        .ADDR_W   (ADDR_W),
        .BOUNDARY (BOUNDARY)
    ) u_judge (
        .acc_req   (acc_req),
        .split_sel (split_sel),
        .wide_acc  (wide_acc),
        .eff_addr  (eff_addr),
        .route     (route)
    );

    xds_pin_drive #(
        .ADDR_W (ADDR_W),
        .IND_W  (IND_W)
    ) u_drive (
        .route    (route),
        .eff_addr (eff_addr),
        .on_chip  (on_chip),
        .ext_addr (ext_addr),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo)
    );
endmodule

// File: rtl/xds_addr_router_chk.sv
module xds_addr_router_chk #(
    parameter int                ADDR_W   = 12,
    parameter int                IND_W    = 8,
    parameter int                PTR_W    = 16,
    parameter logic [ADDR_W-1:0] BOUNDARY = 12'h400
) (
    input logic                    acc_req,
    input logic [1:0]              map_mode,
    input logic                    wide_acc,
    input logic [IND_W-1:0]        ind_ptr,
    input logic [PTR_W-1:0]        data_ptr,
    input logic [ADDR_W-IND_W-1:0] page_reg,
    input logic                    on_chip,
    input logic [ADDR_W-1:0]       ext_addr,
    input logic                    drv_hi,
    input logic                    drv_lo
);
    localparam int PAGE_W = ADDR_W - IND_W;

    always_comb begin
        if (!acc_req) begin
            p_idle_quiet_r10: assert (!on_chip && !drv_hi && !drv_lo && ext_addr == '0);
        end
        if (map_mode != 2'b10) begin
            p_ext_never_onchip_r6: assert (!on_chip);
        end
        if (on_chip) begin
            p_onchip_no_drive_r4: assert (!drv_hi && !drv_lo && ext_addr == '0);
        end
        if (drv_hi) begin
            p_hi_needs_lo_r8: assert (drv_lo);
        end
        if (!drv_hi) begin
            p_hi_lines_zero_r7: assert (ext_addr[ADDR_W-1:IND_W] == '0);
        end
        if (acc_req && map_mode == 2'b10 && !wide_acc && drv_hi) begin
            p_split_page_addr_r2: assert (ext_addr == {page_reg, ind_ptr});
        end
        if (acc_req && map_mode == 2'b10 && wide_acc) begin
            p_split_boundary_r3: assert (on_chip == (data_ptr[ADDR_W-1:0] < BOUNDARY));
        end
        if (acc_req && map_mode != 2'b10 && !wide_acc) begin
            p_ext_short_low_r7: assert (drv_lo && ext_addr[IND_W-1:0] == ind_ptr);
        end
        if (acc_req && map_mode != 2'b10 && wide_acc) begin
            p_ext_wide_full_r8: assert (drv_hi && ext_addr == data_ptr[ADDR_W-1:0]);
        end
    end

    logic unused_pw;
    assign unused_pw = (PAGE_W == 0);
endmodule

bind xds_addr_router xds_addr_router_chk #(
    .ADDR_W   (ADDR_W),
    .IND_W    (IND_W),
    .PTR_W    (PTR_W),
    .BOUNDARY (BOUNDARY)
) u_chk (
    .acc_req  (acc_req),
    .map_mode (map_mode),
    .wide_acc (wide_acc),
    .ind_ptr  (ind_ptr),
    .data_ptr (data_ptr),
    .page_reg (page_reg),
    .on_chip  (on_chip),
    .ext_addr (ext_addr),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo)
);

// File: tb/xds_addr_router_tb.sv
`timescale 1ns/1ps
module xds_addr_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [1:0]  map_mode = 2'b00;
    logic        wide_acc = 1'b0;
    logic [7:0]  ind_ptr = 8'h00;
    logic [15:0] data_ptr = 16'h0000;
    logic [3:0]  page_reg = 4'h0;
    logic        on_chip;
    logic [11:0] ext_addr;
    logic        drv_hi;
    logic        drv_lo;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xds_addr_router u_dut (
        .acc_req  (acc_req),
        .map_mode (map_mode),
        .wide_acc (wide_acc),
        .ind_ptr  (ind_ptr),
        .data_ptr (data_ptr),
        .page_reg (page_reg),
        .on_chip  (on_chip),
        .ext_addr (ext_addr),
        .drv_hi   (drv_hi),
        .drv_lo   (drv_lo)
    );

    // {mode, wide, ind, dptr, page, exp_on, exp_hi, exp_lo, exp_addr}
    localparam int NV = 12;
    localparam logic [45:0] VEC [NV] = '{
        {2'b10, 1'b0, 8'hFF, 16'h0000, 4'h3, 1'b1, 1'b0, 1'b0, 12'h000}, // R2 just below
        {2'b10, 1'b0, 8'h00, 16'h0000, 4'h4, 1'b0, 1'b1, 1'b1, 12'h400}, // R3 at boundary
        {2'b10, 1'b0, 8'hA5, 16'hFFFF, 4'hF, 1'b0, 1'b1, 1'b1, 12'hFA5}, // R4 top page
        {2'b10, 1'b1, 8'hFF, 16'h03FF, 4'hF, 1'b1, 1'b0, 1'b0, 12'h000}, // R5 wide below
        {2'b10, 1'b1, 8'h00, 16'hF400, 4'h0, 1'b0, 1'b1, 1'b1, 12'h400}, // R5 upper bits dropped
        {2'b10, 1'b1, 8'h00, 16'h1234, 4'h0, 1'b1, 1'b0, 1'b0, 12'h000}, // R5 0x234 on-chip
        {2'b11, 1'b0, 8'h3C, 16'h0000, 4'h5, 1'b0, 1'b0, 1'b1, 12'h03C}, // R7 page ignored
        {2'b11, 1'b0, 8'h00, 16'h0000, 4'h0, 1'b0, 1'b0, 1'b1, 12'h000}, // R6 low addr off-chip
        {2'b11, 1'b1, 8'h77, 16'h0010, 4'h9, 1'b0, 1'b1, 1'b1, 12'h010}, // R8 wide low
        {2'b11, 1'b1, 8'h00, 16'hABCD, 4'h0, 1'b0, 1'b1, 1'b1, 12'hBCD}, // R8 wide high
        {2'b00, 1'b0, 8'h11, 16'h0000, 4'h2, 1'b0, 1'b0, 1'b1, 12'h011}, // R9 code 00
        {2'b01, 1'b1, 8'h00, 16'h0100, 4'h0, 1'b0, 1'b1, 1'b1, 12'h100}  // R9 code 01
    };

    task automatic check(input bit ok, input string tag, input logic [14:0] act, input logic [14:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual {on,hi,lo,addr}=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic req, input logic [1:0] m, input logic w,
                         input logic [7:0] ip, input logic [15:0] dp, input logic [3:0] pg);
        @(negedge clk);
        acc_req  = req;
        map_mode = m;
        wide_acc = w;
        ind_ptr  = ip;
        data_ptr = dp;
        page_reg = pg;
        #2;
    endtask

    function automatic logic [14:0] outs();
        return {on_chip, drv_hi, drv_lo, ext_addr};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R10: idle outputs with no request
        apply(1'b0, 2'b10, 1'b0, 8'hFF, 16'hFFFF, 4'hF);
        check(outs() == 15'h0, "R10 idle", outs(), 15'h0);

        // R1..R9 table; each sample is taken in the same cycle as the change (R11)
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][45:44], VEC[i][43], VEC[i][42:35], VEC[i][34:19], VEC[i][18:15]);
            check(outs() == VEC[i][14:0], $sformatf("R1 vector %0d", i), outs(), VEC[i][14:0]);
        end

        // R7: a page change in all-external mode leaves the address alone
        apply(1'b1, 2'b11, 1'b0, 8'h42, 16'h0000, 4'h0);
        begin
            logic [14:0] first;
            first = outs();
            apply(1'b1, 2'b11, 1'b0, 8'h42, 16'h0000, 4'hE);
            check(outs() == first && outs() == 15'h1042, "R7 page ignored", outs(), 15'h1042);
        end

        // R9: code 00 matches code 11 for a wide access
        apply(1'b1, 2'b00, 1'b1, 8'h00, 16'h0C01, 4'h0);
        check(outs() == 15'h3C01, "R9 reserved wide", outs(), 15'h3C01);

        // R3: largest split address
        apply(1'b1, 2'b10, 1'b1, 8'h00, 16'h0FFF, 4'h0);
        check(outs() == 15'h3FFF, "R3 top address", outs(), 15'h3FFF);

        // R11: request drop clears the outputs within the same cycle
        apply(1'b1, 2'b10, 1'b0, 8'h00, 16'h0000, 4'h8);
        check(outs() == 15'h3800, "R11 active", outs(), 15'h3800);
        apply(1'b0, 2'b10, 1'b0, 8'h00, 16'h0000, 4'h8);
        check(outs() == 15'h0, "R11 R10 drop", outs(), 15'h0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule